// File: doc/BRIEF.md
# Inter-core interrupt signalling unit

This unit lets any one of N cores interrupt any other core, and it lets the interrupted core find out which cores interrupted it. All cores share one command port. Each command carries the ID of the core that issues it, a two-bit opcode and one argument field. The argument holds a target core or a sender core, depending on the opcode. The unit stores a pending matrix with one bit for each receiver/sender pair and drives one interrupt line per core.

If several senders raise the same receiver while it is still pending, their requests merge: the receiver sees one asserted line, and its source mask shows every sender that asked. The receiver then acknowledges senders one at a time. Its line stays high until the last sender bit is cleared.

Read-type commands return their result through a readback register. A small readback state machine has two states:
- `RB_IDLE` (no data shown).
- `RB_SHOW` (readback valid).

It has these transitions:
- IDLE→SHOW on a read command.
- SHOW→SHOW on a back-to-back read.
- SHOW→IDLE on any other cycle.

Reset forces `RB_IDLE`.

Top module: `icx_signal_unit`

## Requirements
- R1: Opcode 2'b00 (raise) with issuer `cmd_core`=s and target `cmd_arg`=t, where t≠s, sets the pending bit of sender s at receiver t. `irq_out[t]` is high after the clock edge that samples the command.
- R2: A raise whose target equals its issuer changes no pending bit and no interrupt line.
- R3: A read command (opcode 2'b01 or 2'b10) sampled at an edge makes `rd_valid` high for the following cycle only. While `rd_valid` is low, `rd_data` is zero.
- R4: Opcode 2'b01 (pending query) returns in `rd_data` the sender mask of receiver `cmd_arg`, as it stood when the command was sampled. The mask is nonzero while that receiver has anything pending.
- R5: Opcode 2'b10 (source query) returns the issuer's own sender mask. Bit k is set when core k has an unacknowledged request to the issuer.
- R6: Raises from several senders to one receiver merge into one asserted line, and the receiver's mask then has each of those sender bits set.
- R7: Opcode 2'b11 (acknowledge) clears only the bit of sender `cmd_arg` in the issuer's row. An acknowledge of a bit that is not set changes nothing.
- R8: `irq_out[r]` stays high until every sender bit of receiver r is cleared. It falls after the edge that samples the last acknowledge.
- R9: An active-low reset clears every pending bit, deasserts all interrupt lines and returns the readback to idle.
- R10: Repeating a raise from the same sender while its bit is still pending leaves exactly that one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 00 raise, 01 pending query, 10 source query, 11 acknowledge |
| cmd_core | input | ID_W | ID of the issuing core |
| cmd_arg | input | ID_W | Target core (raise, pending query) or sender core (acknowledge) |
| rd_valid | output | 1 | Readback valid, one cycle after a read command |
| rd_data | output | N_CORES | Readback sender mask |
| irq_out | output | N_CORES | One interrupt line per core |

## Verification
The embedded properties check the following on every cycle:
- A set request is honoured.
- An acknowledge removes its bit.
- A line cannot drop without an acknowledge to that receiver.
- A self-raise leaves the lines untouched.
- Readback valid follows exactly the read commands.
- Reset holds the lines low.

The bench's scenarios cover what a property cannot:
- Data contents: the masks returned for every issuer/target pair, checked against an arithmetic model.
- Merging: several senders raising one receiver and its acknowledges taken one by one.
- Idempotent re-raise.
- A reset issued in the middle of traffic.

// File: rtl/icx_pkg.sv
package icx_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'b00,
        OP_PEND  = 2'b01,
        OP_SRCQ  = 2'b10,
        OP_CLEAR = 2'b11
    } icx_op_e;

    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_SHOW = 1'b1
    } rb_state_e;

endpackage

// File: rtl/icx_cmd_decode.sv
module icx_cmd_decode
    import icx_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ID_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_valid,
    input  logic [1:0]                      cmd_op,
    input  logic [ID_W-1:0]                 cmd_core,
    input  logic [ID_W-1:0]                 cmd_arg,
    output logic [N_CORES-1:0][N_CORES-1:0] set_req,
    output logic [N_CORES-1:0][N_CORES-1:0] clr_req,
    output logic                            rd_req,
    output logic [ID_W-1:0]                 rd_sel
);

    localparam bit FULL_ID = ((1 << ID_W) == N_CORES);

    icx_op_e op;
    logic    core_ok;
    logic    arg_ok;
    logic    is_raise;
    logic    is_clear;

    assign op = icx_op_e'(cmd_op);

    generate
        if (FULL_ID) begin : g_full
            assign core_ok = 1'b1;
            assign arg_ok  = 1'b1;
        end else begin : g_part
            assign core_ok = (int'(cmd_core) < N_CORES);
            assign arg_ok  = (int'(cmd_arg) < N_CORES);
        end
    endgenerate

    assign is_raise = cmd_valid && core_ok && arg_ok && (op == OP_RAISE);
    assign is_clear = cmd_valid && core_ok && arg_ok && (op == OP_CLEAR);

    // Row index = receiver, column index = sender.
    generate
        for (genvar r = 0; r < N_CORES; r++) begin : g_row
            for (genvar s = 0; s < N_CORES; s++) begin : g_col
                if (r == s) begin : g_diag
                    // A core never raises itself.
                    assign set_req[r][s] = 1'b0;
                end else begin : g_off
                    assign set_req[r][s] = is_raise
                        && (cmd_arg == ID_W'(r)) && (cmd_core == ID_W'(s));
                end
                assign clr_req[r][s] = is_clear
                    && (cmd_core == ID_W'(r)) && (cmd_arg == ID_W'(s));
            end
        end
    endgenerate

    always_comb begin
        rd_req = 1'b0;
        rd_sel = cmd_core;
        if (cmd_valid && core_ok && arg_ok) begin
            unique case (op)
                OP_PEND: begin
                    rd_req = 1'b1;
                    rd_sel = cmd_arg;
                end
                OP_SRCQ: begin
                    rd_req = 1'b1;
                    rd_sel = cmd_core;
                end
                OP_RAISE, OP_CLEAR: begin
                    rd_req = 1'b0;
                end
            endcase
        end
    end

    // R1: at most one pair is raised per command.
    p_one_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_req))
        else $error("p_one_set_r1");

    // R7: at most one pair is acknowledged per command.
    p_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_req))
        else $error("p_one_clear_r7");

endmodule

// File: rtl/icx_pend_matrix.sv
module icx_pend_matrix #(
    parameter int N_CORES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_CORES-1:0][N_CORES-1:0] set_req,
    input  logic [N_CORES-1:0][N_CORES-1:0] clr_req,
    output logic [N_CORES-1:0][N_CORES-1:0] pend,
    output logic [N_CORES-1:0]              irq
);

    generate
        for (genvar r = 0; r < N_CORES; r++) begin : g_rx
            // Set dominates clear so a fresh request is never lost.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend[r] <= '0;
                end else begin
                    pend[r] <= (pend[r] & ~clr_req[r]) | set_req[r];
                end
            end

            assign irq[r] = |pend[r];

            // R8: a line only drops when its receiver is acknowledged.
            p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[r] && !(|clr_req[r])) |=> irq[r])
                else $error("p_irq_hold_r8");

            for (genvar s = 0; s < N_CORES; s++) begin : g_tx
                // R1: a raise is recorded.
                p_set_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
                    set_req[r][s] |=> pend[r][s])
                    else $error("p_set_taken_r1");

                // R7: an acknowledge removes its bit.
                p_clear_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_req[r][s] && !set_req[r][s]) |=> !pend[r][s])
                    else $error("p_clear_taken_r7");
            end
        end
    endgenerate

endmodule

// File: rtl/icx_readback.sv
module icx_readback
    import icx_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ID_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_req,
    input  logic [ID_W-1:0]                 rd_sel,
    input  logic [N_CORES-1:0][N_CORES-1:0] pend,
    output logic                            rd_valid,
    output logic [N_CORES-1:0]              rd_data
);

    rb_state_e          state_q;
    rb_state_e          state_d;
    logic [N_CORES-1:0] hold_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_req) begin
            hold_q <= pend[rd_sel];
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RB_IDLE: state_d = rd_req ? RB_SHOW : RB_IDLE;
            RB_SHOW: state_d = rd_req ? RB_SHOW : RB_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RB_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            RB_SHOW: begin
                rd_valid = 1'b1;
                rd_data  = hold_q;
            end
        endcase
    end

    // R3: a read is answered on the next cycle.
    p_rd_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid)
        else $error("p_rd_follow_r3");

    // R3: no valid without a read.
    p_rd_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid)
        else $error("p_rd_only_r3");

endmodule

// File: rtl/icx_signal_unit.sv
module icx_signal_unit
    import icx_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [ID_W-1:0]    cmd_core,
    input  logic [ID_W-1:0]    cmd_arg,
    output logic               rd_valid,
    output logic [N_CORES-1:0] rd_data,
    output logic [N_CORES-1:0] irq_out
);

    logic [N_CORES-1:0][N_CORES-1:0] set_req;
    logic [N_CORES-1:0][N_CORES-1:0] clr_req;
    logic [N_CORES-1:0][N_CORES-1:0] pend;
    logic                            rd_req;
    logic [ID_W-1:0]                 rd_sel;

    icx_cmd_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_arg   (cmd_arg),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .rd_req    (rd_req),
        .rd_sel    (rd_sel)
    );

    icx_pend_matrix #(.N_CORES(N_CORES)) u_matrix (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .pend    (pend),
        .irq     (irq_out)
    );

    icx_readback #(.N_CORES(N_CORES), .ID_W(ID_W)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_sel   (rd_sel),
        .pend     (pend),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R2: raising oneself leaves every line as it was.
    p_self_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'b00) && (cmd_core == cmd_arg))
            |=> $stable(irq_out))
        else $error("p_self_ignored_r2");

    // R9: lines are low while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (irq_out == '0 && !rd_valid)
                else $error("p_reset_quiet_r9");
        end
    end

endmodule

// File: tb/test_icx_signal_unit.sv
module test_icx_signal_unit;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [IW-1:0] cmd_core = '0;
    logic [IW-1:0] cmd_arg = '0;
    logic          rd_valid;
    logic [N-1:0]  rd_data;
    logic [N-1:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] model [N];

    always #5 clk = ~clk;

    icx_signal_unit #(.N_CORES(N)) i_icx_signal_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_arg   (cmd_arg),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_irq();
        logic [N-1:0] v;
        for (int r = 0; r < N; r++) v[r] = |model[r];
        return v;
    endfunction

    // Drives one command, updates the model, checks the cycle after and an idle cycle.
    task automatic cmd(input logic [1:0] op, input int core, input int arg, input string tag);
        logic [N-1:0] exp_rd;
        logic         is_rd;
        is_rd  = (op == 2'b01) || (op == 2'b10);
        exp_rd = (op == 2'b01) ? model[arg] : model[core];
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_core  = IW'(core);
        cmd_arg   = IW'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 2'b00 && core != arg) model[arg][core] = 1'b1;
        if (op == 2'b11) model[core][arg] = 1'b0;
        chk({tag, " irq"}, 32'(irq_out), 32'(model_irq()));
        chk("R3 valid", 32'(rd_valid), 32'(is_rd));
        if (is_rd) chk({tag, " data"}, 32'(rd_data), 32'(exp_rd));
        @(negedge clk);
        chk("R3 idle valid", 32'(rd_valid), 32'h0);
        chk("R3 idle data", 32'(rd_data), 32'h0);
    endtask

    initial begin
        for (int r = 0; r < N; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset irq", 32'(irq_out), 32'h0);
        chk("R9 reset valid", 32'(rd_valid), 32'h0);
        rst_n = 1'b1;

        // Sweep every issuer/target pair.
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                if (s == t) cmd(2'b00, s, t, "R2 self raise");
                else        cmd(2'b00, s, t, "R1 raise");
                cmd(2'b10, t, 0, "R5 source query");
                cmd(2'b01, s, t, "R4 pending query");
                cmd(2'b00, s, t, "R10 repeat raise");
                cmd(2'b10, t, 0, "R10 source query");
                cmd(2'b11, t, s, "R7 acknowledge");
                cmd(2'b01, s, t, "R4 pending cleared");
            end
        end

        // Merge at receiver 2 and acknowledge one by one.
        cmd(2'b00, 0, 2, "R6 raise a");
        cmd(2'b00, 1, 2, "R6 raise b");
        cmd(2'b00, 3, 2, "R6 raise c");
        cmd(2'b10, 2, 0, "R6 merged mask");
        chk("R6 single line", 32'(irq_out), 32'h4);
        cmd(2'b11, 2, 2, "R7 ack unset bit");
        cmd(2'b10, 2, 0, "R7 mask unchanged");
        cmd(2'b11, 2, 0, "R8 ack first");
        cmd(2'b11, 2, 3, "R8 ack second");
        chk("R8 still high", 32'(irq_out[2]), 32'h1);
        cmd(2'b10, 2, 0, "R8 partial mask");
        cmd(2'b11, 2, 1, "R8 ack last");
        chk("R8 line low", 32'(irq_out[2]), 32'h0);

        // Fill several rows, then reset in mid traffic.
        cmd(2'b00, 1, 0, "R1 fill");
        cmd(2'b00, 2, 3, "R1 fill");
        cmd(2'b00, 0, 1, "R1 fill");
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'b01;
        rst_n     = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 mid reset irq", 32'(irq_out), 32'h0);
        chk("R9 mid reset valid", 32'(rd_valid), 32'h0);
        for (int r = 0; r < N; r++) model[r] = '0;
        rst_n = 1'b1;
        for (int r = 0; r < N; r++) cmd(2'b10, r, 0, "R9 row empty");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule